// File: doc/BRIEF.md
# Strap-Selected Management Port and Status Serializer

This block sits on the management pins of a multiport repeater hub. While the synchronous reset is held, it samples two strap levels: a mode strap and the serial-data-in pin. When reset is released it keeps them. The latched mode strap picks one of two uses for the serial clock, serial-in and serial-out pins. The mode and the polarity-correction enable both keep their values until the next reset.

In management mode, the serial clock and serial-in pins come from outside and are asynchronous to the core clock. Each is passed through a two-flop synchronizer. Every rising edge of the synchronized serial clock shifts the serial-in level into a management word. The serial output carries the most significant bit of that word. Port-side logic can load a response word in parallel, and the response then leaves the block one bit per serial clock edge.

In minimum mode, the same two pins become static level selects. The synchronized pair `{sclk, sdi}` picks one of four nine-bit port status vectors. The picked vector is streamed continuously on the serial output, one bit per core clock and most significant bit first. The frame starts again from the first bit whenever the select pair changes.

Top module: `mgmt_strap_serializer`

## Requirements
- R1: While `rst` is high, `sdo` is low from the first clock edge after `rst` is seen high.
- R2: `min_mode` equals the level of `strap_min` during the final cycles of reset. It does not change while `rst` stays low, even if `strap_min` moves.
- R3: `pol_corr_en` is high only when reset ended with both `strap_min` and `sdi` high. It holds until the next reset.
- R4: In minimum mode the select code s = `{sclk, sdi}` streams slice `stat_all[9*s+8 : 9*s]`. The codes are 0 for receive polarity plus the SQE-test error, 1 for bit-rate errors, 2 for link plus AUI loopback, and 3 for partitioning.
- R5: In minimum mode the selected slice is sent highest bit first, one bit per clock, and repeats every 9 clocks without a gap.
- R6: After the select pins change, the highest bit of the new slice appears on `sdo` after the third rising clock edge. This covers two synchronizer flops and one output register.
- R7: In minimum mode, the first clock edge after reset release puts the highest bit of the selected slice on `sdo`.
- R8: In management mode, each rising edge of `sclk` shifts `sdi` into bit 0 of `mgmt_word`. The edge is seen three core clock edges after the pin rises. `sdo` shows bit 15 of `mgmt_word`.
- R9: In management mode, a cycle with `mgmt_load` high copies `mgmt_rsp` into `mgmt_word`. When a serial clock edge falls in the same cycle, the load wins and no shift takes place.
- R10: In management mode `stat_all` has no effect on `sdo`. In minimum mode, activity on `sclk`, `sdi` and `mgmt_load` leaves `mgmt_word` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset, already synchronized to `clk` |
| strap_min | input | 1 | Mode strap, sampled during reset |
| sclk | input | 1 | Serial clock (management) or select high bit (minimum) |
| sdi | input | 1 | Serial data in (management), select low bit (minimum), polarity strap during reset |
| stat_all | input | 36 | Four 9-bit port status vectors, slice s at bits 9s+8..9s |
| mgmt_load | input | 1 | Parallel load strobe for the management word |
| mgmt_rsp | input | 16 | Response word to load |
| sdo | output | 1 | Serial output |
| mgmt_word | output | 16 | Management shift word |
| min_mode | output | 1 | Latched minimum-mode strap |
| pol_corr_en | output | 1 | Latched polarity-correction enable |

## Verification
A wrong bit counter or a stale select register shows on `sdo` as a wrong bit within nine clocks of reset release. It can also show as a missing restart within three clocks of a select change. A wrong strap capture shows on `min_mode` and `pol_corr_en` on the first cycle after reset. It also decides which source drives `sdo`. A faulty edge detector or shift path in management mode shows as a wrong `mgmt_word` after the next serial clock pulse.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int SEL_W = 2;
  localparam int N_VEC = 1 << SEL_W;
  typedef enum logic [SEL_W-1:0] {
    SEL_RXPOL = 2'd0,
    SEL_RATE  = 2'd1,
    SEL_LINK  = 2'd2,
    SEL_PART  = 2'd3
  } stat_sel_e;
endpackage

// File: rtl/mm_sync2.sv
module mm_sync2 #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Synchronizer flops carry no reset, so pin levels are valid during reset.
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic ff1, ff2;
    always_ff @(posedge clk) begin
      ff1 <= d[g];
      ff2 <= ff1;
    end
    assign q[g] = ff2;
  end
endmodule

// File: rtl/mm_strap.sv
module mm_strap (
  input  logic clk,
  input  logic rst,
  input  logic mode_in,
  input  logic pol_in,
  output logic min_mode,
  output logic pol_en
);
  logic mode_q, pol_q;

  // Track the straps while reset is held; freeze at release.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode_in;
      pol_q  <= mode_in & pol_in;
    end
  end

  assign min_mode = mode_q;
  assign pol_en   = pol_q;

  p_strap_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ($stable(mode_q) && $stable(pol_q)));
endmodule

// File: rtl/mm_frame_ser.sv
module mm_frame_ser
  import mm_pkg::*;
#(
  parameter int VEC_W = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [SEL_W-1:0]       sel_now,
  input  logic [N_VEC*VEC_W-1:0] stat_all,
  output logic                   bit_q
);
  localparam int CNT_W = $clog2(VEC_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(VEC_W - 1);

  logic [VEC_W-1:0] vecs [N_VEC];
  for (genvar g = 0; g < N_VEC; g++) begin : g_vec
    assign vecs[g] = stat_all[g*VEC_W +: VEC_W];
  end

  stat_sel_e        sel_q;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      sel_q <= stat_sel_e'(sel_now);
      bit_q <= 1'b0;
    end else if (sel_now != sel_q) begin
      sel_q <= stat_sel_e'(sel_now);
      bit_q <= vecs[sel_now][VEC_W-1];
      cnt   <= CNT_W'(1);
    end else begin
      bit_q <= vecs[sel_q][LAST - cnt];
      cnt   <= (cnt == LAST) ? '0 : cnt + CNT_W'(1);
    end
  end

  p_restart_r6: assert property (@(posedge clk) disable iff (rst || !en)
    (sel_now != sel_q) |=> (cnt == CNT_W'(1)));
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst || !en)
    (sel_now == sel_q && cnt == LAST) |=> (cnt == '0));
  p_cnt_lim_r5: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/mm_mgmt_shift.sv
module mm_mgmt_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         sclk_s,
  input  logic         sdi_s,
  input  logic         load,
  input  logic [W-1:0] rsp,
  output logic [W-1:0] word,
  output logic         msb
);
  logic sclk_d;
  logic rise;

  always_ff @(posedge clk) sclk_d <= sclk_s;
  assign rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else if (en) begin
      if (load)      word <= rsp;
      else if (rise) word <= {word[W-2:0], sdi_s};
    end
  end

  assign msb = word[W-1];

  p_load_r9: assert property (@(posedge clk) disable iff (rst)
    (en && load) |=> (word == $past(rsp)));
  p_shift_r8: assert property (@(posedge clk) disable iff (rst)
    (en && rise && !load) |=> (word[W-1:1] == $past(word[W-2:0])));
  p_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(word));
endmodule

// File: rtl/mgmt_strap_serializer.sv
module mgmt_strap_serializer
  import mm_pkg::*;
#(
  parameter int VEC_W  = 9,
  parameter int MGMT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   strap_min,
  input  logic                   sclk,
  input  logic                   sdi,
  input  logic [N_VEC*VEC_W-1:0] stat_all,
  input  logic                   mgmt_load,
  input  logic [MGMT_W-1:0]      mgmt_rsp,
  output logic                   sdo,
  output logic [MGMT_W-1:0]      mgmt_word,
  output logic                   min_mode,
  output logic                   pol_corr_en
);
  logic [2:0] pins_s;
  logic       strap_s, sclk_s, sdi_s;
  logic       ser_bit, mgmt_msb;

  mm_sync2 #(.W(3)) u_sync (
    .clk (clk),
    .d   ({strap_min, sclk, sdi}),
    .q   (pins_s)
  );
  assign {strap_s, sclk_s, sdi_s} = pins_s;

  mm_strap u_strap (
    .clk      (clk),
    .rst      (rst),
    .mode_in  (strap_s),
    .pol_in   (sdi_s),
    .min_mode (min_mode),
    .pol_en   (pol_corr_en)
  );

  mm_frame_ser #(.VEC_W(VEC_W)) u_ser (
    .clk      (clk),
    .rst      (rst),
    .en       (min_mode),
    .sel_now  ({sclk_s, sdi_s}),
    .stat_all (stat_all),
    .bit_q    (ser_bit)
  );

  mm_mgmt_shift #(.W(MGMT_W)) u_mgmt (
    .clk    (clk),
    .rst    (rst),
    .en     (!min_mode),
    .sclk_s (sclk_s),
    .sdi_s  (sdi_s),
    .load   (mgmt_load),
    .rsp    (mgmt_rsp),
    .word   (mgmt_word),
    .msb    (mgmt_msb)
  );

  // Both sources are registers and the mode is static outside reset.
  assign sdo = min_mode ? ser_bit : mgmt_msb;

  p_rst_low_r1: assert property (@(posedge clk) rst |=> !sdo);
endmodule

// File: tb/sim_mgmt_strap_serializer.sv
module sim_mgmt_strap_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_min = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic [35:0] stat_all;
  logic        mgmt_load = 1'b0;
  logic [15:0] mgmt_rsp = '0;
  logic        sdo;
  logic [15:0] mgmt_word;
  logic        min_mode, pol_corr_en;

  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [8:0] V_POL = 9'h1A5, V_RATE = 9'h0F3,
                         V_LINK = 9'h14C, V_PART = 9'h0B6;

  always #2 clk = ~clk;

  mgmt_strap_serializer u0 (
    .clk(clk), .rst(rst), .strap_min(strap_min), .sclk(sclk), .sdi(sdi),
    .stat_all(stat_all), .mgmt_load(mgmt_load), .mgmt_rsp(mgmt_rsp),
    .sdo(sdo), .mgmt_word(mgmt_word), .min_mode(min_mode),
    .pol_corr_en(pol_corr_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic st, input logic sc, input logic sd);
    @(negedge clk);
    rst = 1'b1; strap_min = st; sclk = sc; sdi = sd;
    repeat (6) @(negedge clk);
    chk("R1 sdo low in reset", sdo, 0);
    rst = 1'b0;
  endtask

  task automatic t_mgmt_straps();
    do_reset(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R2 management mode", min_mode, 0);
    chk("R3 pol off in mgmt mode", pol_corr_en, 0);
    strap_min = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 strap held", min_mode, 0);
    strap_min = 1'b0;
  endtask

  task automatic sclk_pulse(input logic b);
    sdi = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_mgmt_shift();
    logic [15:0] pat = 16'hA5C3;
    for (int i = 15; i >= 0; i--) sclk_pulse(pat[i]);
    chk("R8 word after 16 edges", mgmt_word, pat);
    chk("R8 sdo msb", sdo, pat[15]);
    sclk_pulse(1'b0);
    chk("R8 one more shift", mgmt_word, {pat[14:0], 1'b0});
    chk("R8 sdo next bit", sdo, pat[14]);
  endtask

  task automatic t_mgmt_load();
    logic [15:0] r = 16'h3C96;
    mgmt_rsp = r;
    mgmt_load = 1'b1;
    @(negedge clk);
    mgmt_load = 1'b0;
    chk("R9 loaded word", mgmt_word, r);
    chk("R9 sdo first bit", sdo, r[15]);
    for (int i = 1; i <= 4; i++) begin
      sclk_pulse(1'b0);
      chk("R9 response bit out", sdo, r[15-i]);
    end
    // Load on the same cycle as a detected serial clock edge.
    r = 16'h5A0F; mgmt_rsp = r; sdi = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); mgmt_load = 1'b1;
    @(negedge clk); mgmt_load = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 load beats shift", mgmt_word, r);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_mgmt_ignore_stat();
    logic [15:0] w = mgmt_word;
    logic s = sdo;
    stat_all = ~stat_all;
    repeat (12) @(negedge clk);
    chk("R10 sdo ignores status", sdo, s);
    chk("R10 word ignores status", mgmt_word, w);
    stat_all = ~stat_all;
  endtask

  task automatic t_min_start(input logic sd, input logic [8:0] v);
    do_reset(1'b1, 1'b0, sd);
    for (int k = 1; k <= 18; k++) begin
      @(negedge clk);
      if (k == 1) begin
        chk("R2 minimum mode", min_mode, 1);
        chk("R3 pol strap", pol_corr_en, sd);
      end
      chk("R7 R5 stream from release", sdo, v[8 - ((k-1) % 9)]);
    end
  endtask

  task automatic t_min_sel(input logic sc, input logic sd, input logic [8:0] v);
    sclk = sc; sdi = sd;
    for (int k = 1; k <= 21; k++) begin
      @(negedge clk);
      if (k >= 3) chk("R4 R5 R6 selected stream", sdo, v[8 - ((k-3) % 9)]);
    end
  endtask

  task automatic t_min_mgmt_frozen();
    mgmt_rsp = 16'hFFFF; mgmt_load = 1'b1;
    repeat (3) @(negedge clk);
    mgmt_load = 1'b0;
    chk("R10 word frozen in minimum mode", mgmt_word, 0);
  endtask

  initial begin
    stat_all = {V_PART, V_LINK, V_RATE, V_POL};
    @(negedge clk);
    chk("R1 sdo low at start of reset", sdo, 0);
    t_mgmt_straps();
    t_mgmt_shift();
    t_mgmt_load();
    t_mgmt_ignore_stat();
    t_min_start(1'b1, V_RATE);
    t_min_sel(1'b0, 1'b0, V_POL);
    t_min_sel(1'b1, 1'b0, V_LINK);
    t_min_sel(1'b1, 1'b1, V_PART);
    t_min_sel(1'b0, 1'b1, V_RATE);
    t_min_mgmt_frozen();
    t_min_start(1'b0, V_POL);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule